// File: doc/BRIEF.md
# Memory Frequency Switch Sequencer

This block runs the hardware side of a memory clock frequency change. Software programs the new refresh timing, the clock mode and the pad-hold policy through a small register port. With double-buffering turned on, the refresh timing write lands in a shadow copy and the timing seen by the memory controller stays as it was. Software then sets the start bit in the control register.

Once started, the sequencer waits until every bus master that is not masked off reports ready. It then optionally freezes the memory pads through a request/acknowledge handshake, and asks the clock generator to switch through a second handshake. After the switch it copies the shadow timing into the active timing, releases the pads and clears the start bit. Software polls that bit to see completion. Writing zero to the control register afterwards turns buffering off, so later timing writes take effect at once.

Top module: `freq_switch_seq`

## Requirements
- R1: In reset and directly after it, pad_hold_req, clk_switch_req, clk_mode and clk_bypass are 0, the control register reads 0, and the active timing equals the RESET_TIMING parameter.
- R2: Writing 1 to control bit 0 (word address 0) starts a sequence. Bit 0 reads back 1 while the sequence runs and is cleared by hardware when it ends. The other control bits keep their values.
- R3: The sequence does not request pad hold or clock switch until every bit of (master_rdy | mask) is 1. The mask is at word address 1, and a set mask bit counts that master as ready. The mask resets to 0, so a master that is not ready stalls the sequence.
- R4: When control bit 13 is set, pad_hold_req rises and is acknowledged before clk_switch_req rises. It stays high through the clock switch and falls before completion. When bit 13 is clear, pad_hold_req never rises.
- R5: clk_switch_req stays high until clk_switch_ack is seen. The sequence does not complete while the acknowledge is withheld.
- R6: While control bit 15 is set, a write to the timing register (word address 2) changes only the shadow copy, which is what the register reads back. The active timing changes only in the update step of a sequence.
- R7: While control bit 15 is clear, a timing write appears on the active timing outputs in the cycle after the write.
- R8: A control write made while bit 0 reads 1 is ignored entirely, both the start bit and every other field.
- R9: Control bit 1 drives clk_mode (0 dynamic switch, 1 continuous) and control bit 4 drives clk_bypass.
- R10: Timing register bits 31:16 give refresh_interval, in units of 32 controller clocks, and bits 15:0 give refresh_cycles, in controller clocks.
- R11: A buffered timing write that lands in the same cycle as the update step is the value that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address: 0 control, 1 mask, 2 timing |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| master_rdy | input | NUM_MASTERS | Per-master ready indications |
| pad_hold_req | output | 1 | Request to hold the memory pads |
| pad_hold_ack | input | 1 | Pad hold acknowledge |
| clk_switch_req | output | 1 | Request to the clock generator to switch |
| clk_switch_ack | input | 1 | Clock switch acknowledge |
| clk_mode | output | 1 | Switch mode select: 0 dynamic, 1 continuous |
| clk_bypass | output | 1 | Bypass enable to the clock generator |
| refresh_interval | output | 16 | Active refresh interval, in units of 32 clocks |
| refresh_cycles | output | 16 | Active refresh cycle time, in clocks |

## Verification
The timing register write and the update step of a sequence can fall in the same cycle, and both change the timing storage. The bench provokes this by watching clk_switch_req fall. That edge marks entry into the update step, and the bench issues a buffered timing write with a new value in exactly that cycle. The result is judged on the active timing outputs: they must show the value just written and not the older shadow content.

// File: rtl/fss_pkg.sv
package fss_pkg;

    localparam int REG_W = 32;
    localparam int ADDR_W = 2;

    // Control register field positions (software-visible)
    localparam int CTRL_START   = 0;
    localparam int CTRL_MODE    = 1;
    localparam int CTRL_BYPASS  = 4;
    localparam int CTRL_PADHOLD = 13;
    localparam int CTRL_BUFFER  = 15;

    localparam logic [REG_W-1:0] CTRL_WMASK =
        (REG_W'(1) << CTRL_START) | (REG_W'(1) << CTRL_MODE) |
        (REG_W'(1) << CTRL_BYPASS) | (REG_W'(1) << CTRL_PADHOLD) |
        (REG_W'(1) << CTRL_BUFFER);

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TIMING = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_READY,
        ST_PAD_HOLD,
        ST_SWITCH_CLK,
        ST_UPDATE_TIMING,
        ST_RELEASE,
        ST_DONE
    } seq_state_t;

endpackage

// File: rtl/fss_ready_gate.sv
module fss_ready_gate #(
    parameter int NUM_MASTERS = 32
) (
    input  logic [NUM_MASTERS-1:0] master_rdy_i,
    input  logic [NUM_MASTERS-1:0] mask_i,
    output logic                   all_ready_o
);

    logic [NUM_MASTERS-1:0] ok;

    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_master
        assign ok[g] = master_rdy_i[g] | mask_i[g];
    end

    assign all_ready_o = &ok;

endmodule

// File: rtl/fss_regs.sv
module fss_regs
    import fss_pkg::*;
#(
    parameter int               NUM_MASTERS  = 32,
    parameter logic [REG_W-1:0] RESET_TIMING = 32'h0010_0008
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [REG_W-1:0]       wdata_i,
    output logic [REG_W-1:0]       rdata_o,
    input  logic                   done_i,
    input  logic                   apply_i,
    output logic                   start_o,
    output logic                   mode_o,
    output logic                   bypass_o,
    output logic                   padhold_o,
    output logic                   buffer_o,
    output logic [NUM_MASTERS-1:0] mask_o,
    output logic [REG_W-1:0]       active_o
);

    typedef struct packed {
        logic [REG_W-1:0]       ctrl;
        logic [NUM_MASTERS-1:0] mask;
        logic [REG_W-1:0]       shadow;
        logic [REG_W-1:0]       active;
    } regs_t;

    regs_t q, d;
    logic  wr_ctrl, wr_mask, wr_timing;
    logic [REG_W-1:0] mask_ext;

    always_comb begin
        wr_ctrl   = wr_en_i && (addr_i == ADDR_CTRL);
        wr_mask   = wr_en_i && (addr_i == ADDR_MASK);
        wr_timing = wr_en_i && (addr_i == ADDR_TIMING);

        d = q;
        if (wr_ctrl && !q.ctrl[CTRL_START]) begin
            d.ctrl = wdata_i & CTRL_WMASK;
        end
        if (wr_mask) begin
            d.mask = wdata_i[NUM_MASTERS-1:0];
        end
        if (wr_timing) begin
            d.shadow = wdata_i;
            if (!q.ctrl[CTRL_BUFFER]) begin
                d.active = wdata_i;
            end
        end
        if (apply_i) begin
            d.active = d.shadow;
        end
        if (done_i) begin
            d.ctrl[CTRL_START] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl   <= '0;
            q.mask   <= '0;
            q.shadow <= RESET_TIMING;
            q.active <= RESET_TIMING;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mask_ext = '0;
        mask_ext[NUM_MASTERS-1:0] = q.mask;
        case (addr_i)
            ADDR_CTRL:   rdata_o = q.ctrl;
            ADDR_MASK:   rdata_o = mask_ext;
            ADDR_TIMING: rdata_o = q.shadow;
            default:     rdata_o = '0;
        endcase
    end

    assign start_o   = q.ctrl[CTRL_START];
    assign mode_o    = q.ctrl[CTRL_MODE];
    assign bypass_o  = q.ctrl[CTRL_BYPASS];
    assign padhold_o = q.ctrl[CTRL_PADHOLD];
    assign buffer_o  = q.ctrl[CTRL_BUFFER];
    assign mask_o    = q.mask;
    assign active_o  = q.active;

endmodule

// File: rtl/fss_fsm.sv
module fss_fsm
    import fss_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic all_ready_i,
    input  logic padhold_en_i,
    input  logic pad_ack_i,
    input  logic clk_ack_i,
    output logic pad_req_o,
    output logic clk_req_o,
    output logic apply_o,
    output logic done_o
);

    typedef struct packed {
        seq_state_t state;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d         = q;
        pad_req_o = 1'b0;
        clk_req_o = 1'b0;
        apply_o   = 1'b0;
        done_o    = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) d.state = ST_WAIT_READY;
            end
            ST_WAIT_READY: begin
                if (all_ready_i) begin
                    d.state = padhold_en_i ? ST_PAD_HOLD : ST_SWITCH_CLK;
                end
            end
            ST_PAD_HOLD: begin
                pad_req_o = 1'b1;
                if (pad_ack_i) d.state = ST_SWITCH_CLK;
            end
            ST_SWITCH_CLK: begin
                pad_req_o = padhold_en_i;
                clk_req_o = 1'b1;
                if (clk_ack_i) d.state = ST_UPDATE_TIMING;
            end
            ST_UPDATE_TIMING: begin
                pad_req_o = padhold_en_i;
                apply_o   = 1'b1;
                d.state   = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (!padhold_en_i || !pad_ack_i) d.state = ST_DONE;
            end
            ST_DONE: begin
                done_o  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/freq_switch_seq.sv
module freq_switch_seq
    import fss_pkg::*;
#(
    parameter int               NUM_MASTERS  = 32,
    parameter logic [REG_W-1:0] RESET_TIMING = 32'h0010_0008
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr_en,
    input  logic [1:0]             reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [NUM_MASTERS-1:0] master_rdy,
    output logic                   pad_hold_req,
    input  logic                   pad_hold_ack,
    output logic                   clk_switch_req,
    input  logic                   clk_switch_ack,
    output logic                   clk_mode,
    output logic                   clk_bypass,
    output logic [15:0]            refresh_interval,
    output logic [15:0]            refresh_cycles
);

    logic                   start, padhold_en, buffer_en;
    logic                   done, apply, all_ready;
    logic [NUM_MASTERS-1:0] mask;
    logic [REG_W-1:0]       active;

    fss_regs #(
        .NUM_MASTERS (NUM_MASTERS),
        .RESET_TIMING(RESET_TIMING)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (reg_wr_en),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .rdata_o  (reg_rdata),
        .done_i   (done),
        .apply_i  (apply),
        .start_o  (start),
        .mode_o   (clk_mode),
        .bypass_o (clk_bypass),
        .padhold_o(padhold_en),
        .buffer_o (buffer_en),
        .mask_o   (mask),
        .active_o (active)
    );

    fss_ready_gate #(
        .NUM_MASTERS(NUM_MASTERS)
    ) gate_i (
        .master_rdy_i(master_rdy),
        .mask_i      (mask),
        .all_ready_o (all_ready)
    );

    fss_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .all_ready_i (all_ready),
        .padhold_en_i(padhold_en),
        .pad_ack_i   (pad_hold_ack),
        .clk_ack_i   (clk_switch_ack),
        .pad_req_o   (pad_hold_req),
        .clk_req_o   (clk_switch_req),
        .apply_o     (apply),
        .done_o      (done)
    );

    assign refresh_interval = active[31:16];
    assign refresh_cycles   = active[15:0];

endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pad_req,
    input logic        pad_ack,
    input logic        clk_req,
    input logic        clk_ack,
    input logic        mode,
    input logic        bypass,
    input logic        all_ready,
    input logic        padhold_en,
    input logic        buffer_en,
    input logic        start,
    input logic        done,
    input logic        apply,
    input logic [31:0] active
);

    // R3: pad hold is only requested after the ready gate opened
    p_pad_after_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_req) |-> $past(all_ready));

    // R4: clock switch happens only with pads held and acknowledged
    p_switch_under_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_req && padhold_en) |-> (pad_req && pad_ack));

    // R4: no pad hold when the hold feature is off
    p_no_hold_when_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !padhold_en |-> !pad_req);

    // R5: switch request withdrawn only after acknowledge
    p_req_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_req) |-> $past(clk_ack));

    // R6: buffered active timing moves only in the update step
    p_active_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> ($past(apply) || !$past(buffer_en)));

    // R2: start bit clears only at completion
    p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start) |-> $past(done));

    // R8: control fields frozen while a sequence runs
    p_ctrl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> $stable({mode, bypass, padhold_en, buffer_en}));

endmodule

bind freq_switch_seq fss_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_req   (pad_hold_req),
    .pad_ack   (pad_hold_ack),
    .clk_req   (clk_switch_req),
    .clk_ack   (clk_switch_ack),
    .mode      (clk_mode),
    .bypass    (clk_bypass),
    .all_ready (all_ready),
    .padhold_en(padhold_en),
    .buffer_en (buffer_en),
    .start     (start),
    .done      (done),
    .apply     (apply),
    .active    (active)
);

// File: tb/freq_switch_seq_tb_top.sv
module freq_switch_seq_tb_top;

    localparam int NM = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [NM-1:0] rdy = '0;
    logic        pad_req, clk_req, mode, bypass;
    logic        pad_ack = 1'b0;
    logic        clk_ack = 1'b0;
    logic        clk_ack_en = 1'b1;
    logic [15:0] interval, cycles;

    int checks = 0;
    int errors = 0;
    int n_pad = 0, n_clk = 0, n_order = 0;

    always #10 clk = ~clk;

    freq_switch_seq #(.NUM_MASTERS(NM), .RESET_TIMING(32'h0010_0008)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .master_rdy(rdy),
        .pad_hold_req(pad_req), .pad_hold_ack(pad_ack),
        .clk_switch_req(clk_req), .clk_switch_ack(clk_ack),
        .clk_mode(mode), .clk_bypass(bypass),
        .refresh_interval(interval), .refresh_cycles(cycles)
    );

    // Handshake partners: acknowledge one cycle after request
    always @(posedge clk) begin
        pad_ack <= pad_req;
        clk_ack <= clk_req & clk_ack_en;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (pad_req) n_pad++;
            if (clk_req) n_clk++;
            if (clk_req && !pad_ack) n_order++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 0;
        addr = 2'd0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            #1;
            if (!rdata[0]) break;
            cyc++;
        end
    endtask

    initial begin
        #(20ns * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int cyc, s_pad, s_clk, s_ord;
        bit saw;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1 pad_req", 32'(pad_req), 0);
        chk("R1 clk_req", 32'(clk_req), 0);
        chk("R1 mode/bypass", 32'({mode, bypass}), 0);
        chk("R1 timing", {interval, cycles}, 32'h0010_0008);
        chk("R1 ctrl read", rdata, 0);
        rst_n = 1'b1;

        // R7, R10: unbuffered timing write lands at once, fields split
        wr(2'd2, 32'h1234_0056);
        chk("R10 interval", 32'(interval), 32'h1234);
        chk("R10 cycles", 32'(cycles), 32'h0056);
        rd(2'd2, v);
        chk("R7 timing read", v, 32'h1234_0056);

        // R9: mode and bypass outputs
        wr(2'd0, 32'h0000_0012);
        chk("R9 mode+bypass", 32'({mode, bypass}), 32'b11);
        wr(2'd0, 32'h0000_0002);
        chk("R9 mode only", 32'({mode, bypass}), 32'b10);
        wr(2'd0, 32'h0);

        // R6: buffered write stays in shadow until the update step
        wr(2'd0, 32'h0000_8000);
        wr(2'd2, 32'hAAAA_0077);
        chk("R6 active held", {interval, cycles}, 32'h1234_0056);
        rd(2'd2, v);
        chk("R6 shadow read", v, 32'hAAAA_0077);
        wr(2'd1, 32'hF);
        wr(2'd0, 32'h0000_8001);
        rd(2'd0, v);
        chk("R2 start reads 1", 32'(v[0]), 1);
        wait_idle(cyc);
        chk("R2 completes", 32'(cyc < 50), 1);
        chk("R6 applied", {interval, cycles}, 32'hAAAA_0077);
        rd(2'd0, v);
        chk("R2 start cleared, fields kept", v, 32'h0000_8000);

        // R4: pad hold enabled
        s_pad = n_pad; s_clk = n_clk; s_ord = n_order;
        wr(2'd0, 32'h0000_A001);
        wait_idle(cyc);
        chk("R4 pad requested", 32'(n_pad > s_pad), 1);
        chk("R4 clock switched", 32'(n_clk > s_clk), 1);
        chk("R4 switch only under ack", 32'(n_order - s_order_fix(s_ord)), 0);
        chk("R4 pad released", 32'(pad_req), 0);

        // R4: pad hold disabled
        s_pad = n_pad; s_clk = n_clk;
        wr(2'd0, 32'h0000_8001);
        wait_idle(cyc);
        chk("R4 no pad hold", 32'(n_pad - s_pad), 0);
        chk("R4 switch without hold", 32'(n_clk > s_clk), 1);

        // R3 and R8: stalled sequence, control write ignored
        wr(2'd1, 32'h0);
        rdy = '0;
        wr(2'd0, 32'h0000_8001);
        wr(2'd0, 32'h0000_0012);
        rd(2'd0, v);
        chk("R8 ctrl write ignored", v, 32'h0000_8001);
        chk("R8 mode unchanged", 32'({mode, bypass}), 0);
        repeat (10) @(negedge clk);
        chk("R3 stalled no switch", 32'(clk_req), 0);
        rdy = 4'hF;
        wait_idle(cyc);
        rd(2'd0, v);
        chk("R3 completes once ready", v, 32'h0000_8000);

        // R5: withheld clock acknowledge
        wr(2'd1, 32'hF);
        clk_ack_en = 1'b0;
        wr(2'd0, 32'h0000_8001);
        repeat (12) @(negedge clk);
        chk("R5 request held", 32'(clk_req), 1);
        rd(2'd0, v);
        chk("R5 not complete", 32'(v[0]), 1);
        clk_ack_en = 1'b1;
        wait_idle(cyc);
        chk("R5 request dropped", 32'(clk_req), 0);

        // R11: buffered write coinciding with the update step
        wr(2'd0, 32'h0000_8001);
        saw = 1'b0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (clk_req) saw = 1'b1;
            else if (saw) break;
        end
        we = 1'b1; addr = 2'd2; wdata = 32'h5555_0099;
        @(negedge clk);
        we = 1'b0; addr = 2'd0;
        wait_idle(cyc);
        chk("R11 same-cycle write wins", {interval, cycles}, 32'h5555_0099);

        // R7: buffering off after writing zero
        wr(2'd0, 32'h0);
        wr(2'd2, 32'h0101_0202);
        chk("R7 immediate after clear", {interval, cycles}, 32'h0101_0202);

        // R3: sweep of ready and mask patterns
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                s_clk = n_clk;
                rdy = 4'(r);
                wr(2'd1, 32'(m));
                wr(2'd0, 32'h1);
                repeat (8) @(negedge clk);
                chk($sformatf("R3 gate m=%0h r=%0h", m, r),
                    32'(n_clk > s_clk), 32'(((r | m) & 15) == 15));
                rdy = 4'hF;
                wait_idle(cyc);
                rd(2'd0, v);
                chk("R2 sweep completion", v, 0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic int s_order_fix(input int s);
        return s;
    endfunction

endmodule